// File: doc/BRIEF.md
# Ternary Match Array with Entry Status

This block is a small ternary content-addressable array for prefix lookup. Every entry stores a value, a care mask and a two-bit status: invalid, valid, hit or updating. A search path loads a key into a compare register and matches it against all entries that are not invalid, all at once. The lowest-addressed matching entry wins. Its address is the result, meant to index an external next-hop memory.

A separate maintenance port writes, commits and deletes entries while searches continue. A write puts an entry into the updating state. A commit returns it to valid. If a search matches an entry that is still being updated, the result is suspended. The key stays in the compare register and is matched again on every cycle until the entry settles.

An exact hit moves the winning entry to the hit state. The entry stays locked against maintenance until the downstream logic signals that it has latched the result address. The block also tracks the lowest invalid entry as the next free location for inserts, and raises a full flag when no invalid entry is left.

Top module: `tcam_status_array`

## Requirements
- R1: An entry matches the key when, for every bit, either the entry's mask bit is 1 (don't care) or the value bit equals the key bit.
- R2: Maintenance op codes are 0 none, 1 write, 2 commit and 3 delete. A write stores the value and mask and sets the entry to updating. A commit moves an updating entry to valid and leaves any other status unchanged. A delete sets the entry to invalid. An accepted op pulses `mnt_ack_o` for one cycle, one cycle after the request.
- R3: Invalid entries never match. A delete changes only the status, so a deleted entry stops matching even though its value and mask are still stored.
- R4: A search is accepted only while `search_ready_o` is high. The edge that accepts it loads the key into the compare register and drops `search_ready_o`. `search_valid_i` is ignored while `search_ready_o` is low.
- R5: When several entries match, the lowest address is reported on `result_addr_o`.
- R6: Exact hits are reported this way:
  - If the winning entry is valid, `match_o` and `hit_o` rise one cycle after the key is loaded, and the entry moves to hit.
  - `hit_o`, `match_o` and the address then hold until `latch_i` is seen.
  - The cycle after `latch_i`, the entry is valid again, `match_o` is low and `search_ready_o` is high.
- R7: Suspended hits are reported this way:
  - If the winning entry is updating, `match_o` and `suspended_o` are high and `result_addr_o` shows that entry.
  - The held key is matched again on every cycle.
  - Once the entry is committed, the search becomes an exact hit.
- R8: If no entry matches, `miss_o` pulses for one cycle, `match_o` stays low and `search_ready_o` returns high.
- R9: A maintenance op whose target is in the hit state is rejected. So is an op whose target is being moved to hit on that same edge. A rejected op pulses `mnt_busy_o` for one cycle and leaves the entry unchanged.
- R10: After every edge, `free_addr_o` holds the lowest-addressed invalid entry. `full_o` is high, with `free_addr_o` equal to 0, when no invalid entry exists.
- R11: After reset, all entries are invalid, `search_ready_o` is high, and all flags and `free_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| search_valid_i | input | 1 | Search request |
| search_key_i | input | KEY_W | Search key |
| latch_i | input | 1 | Result address latched downstream; releases the hit entry |
| search_ready_o | output | 1 | Search path idle, a new key is accepted |
| match_o | output | 1 | Exact or suspended hit outstanding |
| hit_o | output | 1 | Exact hit, address valid until latched |
| suspended_o | output | 1 | Winning entry is updating; result withheld |
| miss_o | output | 1 | One-cycle pulse: no entry matched |
| result_addr_o | output | AW | Address of the winning entry |
| mnt_op_i | input | 2 | Maintenance op: 0 none, 1 write, 2 commit, 3 delete |
| mnt_addr_i | input | AW | Maintenance target entry |
| mnt_value_i | input | KEY_W | Value to store on write |
| mnt_mask_i | input | KEY_W | Mask to store on write (1 = don't care) |
| mnt_ack_o | output | 1 | One-cycle pulse: op accepted |
| mnt_busy_o | output | 1 | One-cycle pulse: op rejected, target locked |
| free_addr_o | output | AW | Lowest invalid entry |
| full_o | output | 1 | No invalid entry left |

## Verification
A key loaded on edge N produces hit, suspended or miss on edge N+1. After `latch_i` on edge M, the flags clear and the block is ready on edge M+1. Maintenance acknowledgement, busy, free address and full all update on the edge that applies the op. The bench drives inputs on the falling edge and steps a behavioural model on every rising edge, applying these same latencies. It compares every output at the next falling edge, so each expectation is checked in exactly the cycle it is due. Directed checks pin down the constant results: the masked match, priority among several matches, the miss after a delete, the suspended-to-exact transition after a commit, and the same-edge conflict rejection.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_VAL = 2'd1,
    ST_HIT = 2'd2,
    ST_UPD = 2'd3
  } tcam_st_e;

  typedef enum logic [1:0] {
    OP_NOP    = 2'd0,
    OP_WRITE  = 2'd1,
    OP_COMMIT = 2'd2,
    OP_DELETE = 2'd3
  } tcam_op_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOOK = 2'd1,
    S_HOLD = 2'd2
  } srch_state_e;
endpackage

// File: rtl/tcam_ff1.sv
module tcam_ff1 #(
  parameter int N  = 16,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest set index wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        idx_o = IW'(k);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcam_entry.sv
module tcam_entry
  import tcam_pkg::*;
#(
  parameter int KEY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [KEY_W-1:0] val_i,
  input  logic [KEY_W-1:0] msk_i,
  input  tcam_st_e         st_d_i,
  input  logic [KEY_W-1:0] key_i,
  output tcam_st_e         st_o,
  output logic             match_o
);
  logic [KEY_W-1:0] val_q, msk_q;
  tcam_st_e         st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      msk_q <= '0;
      st_q  <= ST_INV;
    end else begin
      st_q <= st_d_i;
      if (ld_i) begin
        val_q <= val_i;
        msk_q <= msk_i;
      end
    end
  end

  // mask bit 1 = don't care
  assign match_o = (st_q != ST_INV) && (&(~(val_q ^ key_i) | msk_q));
  assign st_o    = st_q;
endmodule

// File: rtl/tcam_search_ctl.sv
module tcam_search_ctl
  import tcam_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int AW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             search_valid_i,
  input  logic [KEY_W-1:0] search_key_i,
  input  logic             latch_i,
  input  logic             win_any_i,
  input  tcam_st_e         win_st_i,
  input  logic [AW-1:0]    win_idx_i,
  output logic [KEY_W-1:0] key_o,
  output logic             promote_o,
  output logic             release_o,
  output logic             ready_o,
  output logic             match_o,
  output logic             hit_o,
  output logic             suspended_o,
  output logic             miss_o,
  output logic [AW-1:0]    result_addr_o
);
  srch_state_e      state_q;
  logic [KEY_W-1:0] key_q;
  logic             match_q, susp_q, miss_q;
  logic [AW-1:0]    addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      key_q   <= '0;
      match_q <= 1'b0;
      susp_q  <= 1'b0;
      miss_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      miss_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (search_valid_i) begin
            key_q   <= search_key_i;
            state_q <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (!win_any_i) begin
            state_q <= S_IDLE;
            match_q <= 1'b0;
            susp_q  <= 1'b0;
            miss_q  <= 1'b1;
          end else if (win_st_i == ST_UPD) begin
            // key held, re-evaluated next cycle
            match_q <= 1'b1;
            susp_q  <= 1'b1;
            addr_q  <= win_idx_i;
          end else begin
            state_q <= S_HOLD;
            match_q <= 1'b1;
            susp_q  <= 1'b0;
            addr_q  <= win_idx_i;
          end
        end
        S_HOLD: begin
          if (latch_i) begin
            state_q <= S_IDLE;
            match_q <= 1'b0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign promote_o     = (state_q == S_LOOK) && win_any_i && (win_st_i == ST_VAL);
  assign release_o     = (state_q == S_HOLD) && latch_i;
  assign key_o         = key_q;
  assign ready_o       = (state_q == S_IDLE);
  assign hit_o         = (state_q == S_HOLD);
  assign match_o       = match_q;
  assign suspended_o   = susp_q;
  assign miss_o        = miss_q;
  assign result_addr_o = addr_q;
endmodule

// File: rtl/tcam_status_array.sv
module tcam_status_array
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 16,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             search_valid_i,
  input  logic [KEY_W-1:0] search_key_i,
  input  logic             latch_i,
  output logic             search_ready_o,
  output logic             match_o,
  output logic             hit_o,
  output logic             suspended_o,
  output logic             miss_o,
  output logic [AW-1:0]    result_addr_o,
  input  logic [1:0]       mnt_op_i,
  input  logic [AW-1:0]    mnt_addr_i,
  input  logic [KEY_W-1:0] mnt_value_i,
  input  logic [KEY_W-1:0] mnt_mask_i,
  output logic             mnt_ack_o,
  output logic             mnt_busy_o,
  output logic [AW-1:0]    free_addr_o,
  output logic             full_o
);
  tcam_st_e         st_q [ENTRIES];
  tcam_st_e         st_d [ENTRIES];
  logic [ENTRIES-1:0] match_vec, inv_d_vec;
  logic [KEY_W-1:0] cmp_key;
  logic [AW-1:0]    win_idx, free_d;
  logic             win_any, free_any;
  tcam_st_e         win_st;
  logic             promote, release_hit;
  tcam_op_e         op;
  logic             op_req, op_ok, conflict;
  logic             ack_q, busy_q, full_q;
  logic [AW-1:0]    free_q;

  assign op       = tcam_op_e'(mnt_op_i);
  assign win_st   = st_q[win_idx];
  assign op_req   = (op != OP_NOP);
  // target locked now, or being locked on this edge
  assign conflict = promote && (win_idx == mnt_addr_i);
  assign op_ok    = op_req && (st_q[mnt_addr_i] != ST_HIT) && !conflict;

  tcam_ff1 #(.N(ENTRIES), .IW(AW)) u_win (
    .req_i (match_vec),
    .idx_o (win_idx),
    .any_o (win_any)
  );

  tcam_search_ctl #(.KEY_W(KEY_W), .AW(AW)) u_ctl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .search_valid_i (search_valid_i),
    .search_key_i   (search_key_i),
    .latch_i        (latch_i),
    .win_any_i      (win_any),
    .win_st_i       (win_st),
    .win_idx_i      (win_idx),
    .key_o          (cmp_key),
    .promote_o      (promote),
    .release_o      (release_hit),
    .ready_o        (search_ready_o),
    .match_o        (match_o),
    .hit_o          (hit_o),
    .suspended_o    (suspended_o),
    .miss_o         (miss_o),
    .result_addr_o  (result_addr_o)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sel, ld;
    assign sel = op_ok && (mnt_addr_i == AW'(i));
    assign ld  = sel && (op == OP_WRITE);

    always_comb begin
      st_d[i] = st_q[i];
      if (sel) begin
        unique case (op)
          OP_WRITE:  st_d[i] = ST_UPD;
          OP_COMMIT: if (st_q[i] == ST_UPD) st_d[i] = ST_VAL;
          OP_DELETE: st_d[i] = ST_INV;
          default:   st_d[i] = st_q[i];
        endcase
      end
      if (promote && (win_idx == AW'(i)))           st_d[i] = ST_HIT;
      if (release_hit && (result_addr_o == AW'(i))) st_d[i] = ST_VAL;
    end

    assign inv_d_vec[i] = (st_d[i] == ST_INV);

    tcam_entry #(.KEY_W(KEY_W)) u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ld_i    (ld),
      .val_i   (mnt_value_i),
      .msk_i   (mnt_mask_i),
      .st_d_i  (st_d[i]),
      .key_i   (cmp_key),
      .st_o    (st_q[i]),
      .match_o (match_vec[i])
    );
  end

  tcam_ff1 #(.N(ENTRIES), .IW(AW)) u_free (
    .req_i (inv_d_vec),
    .idx_o (free_d),
    .any_o (free_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      busy_q <= 1'b0;
      free_q <= '0;
      full_q <= 1'b0;
    end else begin
      ack_q  <= op_ok;
      busy_q <= op_req && !op_ok;
      free_q <= free_d;
      full_q <= !free_any;
    end
  end

  assign mnt_ack_o   = ack_q;
  assign mnt_busy_o  = busy_q;
  assign free_addr_o = free_q;
  assign full_o      = full_q;
endmodule

// File: rtl/tcam_status_array_chk.sv
module tcam_status_array_chk #(
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          search_valid_i,
  input logic          latch_i,
  input logic          search_ready_o,
  input logic          match_o,
  input logic          hit_o,
  input logic          suspended_o,
  input logic          miss_o,
  input logic [AW-1:0] result_addr_o,
  input logic [1:0]    mnt_op_i,
  input logic [AW-1:0] mnt_addr_i,
  input logic          mnt_ack_o,
  input logic          mnt_busy_o,
  input logic [AW-1:0] free_addr_o,
  input logic          full_o
);
  assert_accept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    search_valid_i && search_ready_o |=> !search_ready_o);

  assert_hit_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> match_o && !suspended_o);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !latch_i |=> hit_o && $stable(result_addr_o));

  assert_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && latch_i |=> !match_o && search_ready_o);

  assert_susp_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspended_o |-> match_o && !search_ready_o);

  assert_miss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> !match_o && search_ready_o);

  assert_resp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mnt_ack_o && mnt_busy_o));

  assert_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mnt_op_i != 2'd0) && hit_o && (mnt_addr_i == result_addr_o) |=> mnt_busy_o);

  assert_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> free_addr_o == '0);
endmodule

bind tcam_status_array tcam_status_array_chk #(.AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .search_valid_i (search_valid_i),
  .latch_i        (latch_i),
  .search_ready_o (search_ready_o),
  .match_o        (match_o),
  .hit_o          (hit_o),
  .suspended_o    (suspended_o),
  .miss_o         (miss_o),
  .result_addr_o  (result_addr_o),
  .mnt_op_i       (mnt_op_i),
  .mnt_addr_i     (mnt_addr_i),
  .mnt_ack_o      (mnt_ack_o),
  .mnt_busy_o     (mnt_busy_o),
  .free_addr_o    (free_addr_o),
  .full_o         (full_o)
);

// File: tb/sim_tcam_status_array.sv
module sim_tcam_status_array;
  localparam int N  = 16;
  localparam int KW = 16;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sv = 1'b0;
  logic [KW-1:0] skey = '0;
  logic          lat = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [AW-1:0] maddr = '0;
  logic [KW-1:0] mval = '0, mmsk = '0;
  logic          ready, match, hit, susp, miss, ack, busy, full;
  logic [AW-1:0] raddr, faddr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tcam_status_array #(.ENTRIES(N), .KEY_W(KW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .search_valid_i(sv), .search_key_i(skey), .latch_i(lat),
    .search_ready_o(ready), .match_o(match), .hit_o(hit),
    .suspended_o(susp), .miss_o(miss), .result_addr_o(raddr),
    .mnt_op_i(op), .mnt_addr_i(maddr), .mnt_value_i(mval), .mnt_mask_i(mmsk),
    .mnt_ack_o(ack), .mnt_busy_o(busy), .free_addr_o(faddr), .full_o(full)
  );

  // reference model: 0 inv, 1 valid, 2 hit, 3 updating; state 0 idle, 1 look, 2 hold
  int          m_st [N];
  logic [KW-1:0] m_val [N], m_msk [N];
  int          m_state, m_addr, m_free;
  logic [KW-1:0] m_key;
  bit          m_match, m_susp, m_miss, m_ack, m_busy, m_full;

  function automatic bit tmatch(logic [KW-1:0] v, logic [KW-1:0] m, logic [KW-1:0] k);
    for (int b = 0; b < KW; b++)
      if (!m[b] && (v[b] != k[b])) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_st[i] = 0; m_val[i] = '0; m_msk[i] = '0;
      end
      m_state = 0; m_addr = 0; m_free = 0; m_key = '0;
      m_match = 0; m_susp = 0; m_miss = 0; m_ack = 0; m_busy = 0; m_full = 0;
    end else begin
      int w;
      bit prom, acc;
      w = -1;
      for (int i = N - 1; i >= 0; i--)
        if (m_st[i] != 0 && tmatch(m_val[i], m_msk[i], m_key)) w = i;
      prom = (m_state == 1) && (w >= 0) && (m_st[w] == 1);
      acc  = (op != 0) && (m_st[int'(maddr)] != 2) && !(prom && w == int'(maddr));
      m_ack = acc; m_busy = (op != 0) && !acc; m_miss = 0;
      case (m_state)
        0: if (sv) begin m_key = skey; m_state = 1; end
        1: begin
          if (w < 0) begin
            m_state = 0; m_match = 0; m_susp = 0; m_miss = 1;
          end else if (m_st[w] == 3) begin
            m_match = 1; m_susp = 1; m_addr = w;
          end else begin
            m_st[w] = 2; m_state = 2; m_match = 1; m_susp = 0; m_addr = w;
          end
        end
        default: if (lat) begin m_st[m_addr] = 1; m_state = 0; m_match = 0; end
      endcase
      if (acc) begin
        case (op)
          2'd1: begin m_val[int'(maddr)] = mval; m_msk[int'(maddr)] = mmsk; m_st[int'(maddr)] = 3; end
          2'd2: if (m_st[int'(maddr)] == 3) m_st[int'(maddr)] = 1;
          default: m_st[int'(maddr)] = 0;
        endcase
      end
      m_full = 1; m_free = 0;
      for (int i = N - 1; i >= 0; i--)
        if (m_st[i] == 0) begin m_free = i; m_full = 0; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 ready", int'(ready), int'(m_state == 0));
      chk("R6 match", int'(match), int'(m_match));
      chk("R6 hit", int'(hit), int'(m_state == 2));
      chk("R7 suspended", int'(susp), int'(m_susp));
      chk("R8 miss", int'(miss), int'(m_miss));
      chk("R5 result_addr", int'(raddr), m_addr);
      chk("R2 ack", int'(ack), int'(m_ack));
      chk("R9 busy", int'(busy), int'(m_busy));
      chk("R10 free_addr", int'(faddr), m_free);
      chk("R10 full", int'(full), int'(m_full));
    end
  end

  task automatic mnt(input logic [1:0] o, input int a, input logic [KW-1:0] v, input logic [KW-1:0] m);
    op = o; maddr = AW'(a); mval = v; mmsk = m;
    @(negedge clk);
    op = 2'd0;
  endtask

  task automatic search(input logic [KW-1:0] k);
    sv = 1'b1; skey = k;
    @(negedge clk);
    sv = 1'b0;
  endtask

  task automatic latch1();
    lat = 1'b1;
    @(negedge clk);
    lat = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 ready", int'(ready), 1);
    chk("R11 match", int'(match), 0);
    chk("R11 free", int'(faddr), 0);
    chk("R11 full", int'(full), 0);

    mnt(2'd1, 3, 16'h1200, 16'h00FF); mnt(2'd2, 3, '0, '0);
    mnt(2'd1, 1, 16'h12AB, 16'h0000); mnt(2'd2, 1, '0, '0);
    mnt(2'd1, 5, 16'h0000, 16'hFFFF); mnt(2'd2, 5, '0, '0);
    chk("R10 free after writes", int'(faddr), 0);

    // R5: entries 1,3,5 all match; lowest wins
    search(16'h12AB); @(negedge clk);
    chk("R5 priority addr", int'(raddr), 1);
    chk("R6 exact hit", int'(hit), 1);
    latch1();
    chk("R6 released", int'(ready), 1);

    // R1: masked low byte matches entry 3
    search(16'h1234); @(negedge clk);
    chk("R1 masked match addr", int'(raddr), 3);
    mnt(2'd1, 3, 16'hFFFF, 16'h0000);
    chk("R9 write to hit entry busy", int'(busy), 1);
    mnt(2'd3, 3, '0, '0);
    chk("R9 delete of hit entry busy", int'(busy), 1);
    latch1();

    search(16'h5555); @(negedge clk);
    chk("R1 all-don't-care entry", int'(raddr), 5);
    latch1();

    // R3: deleted entry no longer matches
    mnt(2'd3, 5, '0, '0);
    chk("R10 free stays lowest", int'(faddr), 0);
    search(16'h5555); @(negedge clk);
    chk("R3 deleted entry miss", int'(miss), 1);

    // R7: suspended hit until commit
    mnt(2'd1, 1, 16'h12AB, 16'h0000);
    search(16'h12AB); @(negedge clk);
    chk("R7 suspended", int'(susp), 1);
    chk("R7 suspended addr", int'(raddr), 1);
    @(negedge clk); @(negedge clk);
    chk("R7 still suspended", int'(susp), 1);
    mnt(2'd2, 1, '0, '0);
    @(negedge clk);
    chk("R7 becomes exact hit", int'(hit), 1);
    latch1();

    // R9: write lands on the promoting edge
    search(16'h12AB);
    mnt(2'd1, 1, 16'h0000, 16'h0000);
    chk("R9 same-edge conflict busy", int'(busy), 1);
    chk("R6 hit after conflict", int'(raddr), 1);
    latch1();

    // R4: request ignored while busy
    search(16'h1234);
    sv = 1'b1; skey = 16'h12AB; @(negedge clk); sv = 1'b0;
    chk("R4 ignored, first key kept", int'(raddr), 3);
    latch1();

    // R10 fill
    for (int i = 0; i < N; i++) mnt(2'd1, i, 16'(i), 16'h0000);
    chk("R10 full", int'(full), 1);
    mnt(2'd3, 7, '0, '0);
    chk("R10 free after delete", int'(faddr), 7);

    // mixed random traffic, model-compared every cycle
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      sv = (r < 35);
      skey = {12'h120, 4'($urandom_range(0, 15))};
      lat = ($urandom_range(0, 99) < 30);
      r = int'($urandom_range(0, 99));
      op = (r < 40) ? 2'($urandom_range(1, 3)) : 2'd0;
      maddr = AW'($urandom_range(0, N - 1));
      mval = {12'h120, 4'($urandom_range(0, 15))};
      mmsk = {12'h000, 4'($urandom_range(0, 15) & $urandom_range(0, 15))};
      @(negedge clk);
    end
    sv = 1'b0; lat = 1'b0; op = 2'd0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule